// File: doc/BRIEF.md
# Store Buffer with Selectable Read Ordering

This block sits between a processor's load/store port and a slower memory port that serves one request at a time. In its buffered policies it takes a store into a small queue, acknowledges it in the same cycle, and writes the queued stores to memory later, oldest first. The processor keeps running while those writes drain.

A two-bit policy input chooses how loads relate to queued stores. The first policy is fully synchronous: nothing is queued, and every access holds the processor until memory answers. This suits the strictest ordering model. The second policy queues stores, but a load waits until the queue is empty; this suits sequential consistency. The third policy lets a load reach memory ahead of queued stores, which suits processor, weak and release consistency. In the third policy a load whose address matches a queued store is answered at once from the youngest matching entry.

A fence request from the processor is acknowledged only once every queued store has been written. This holds in every policy.

Top module: `store_buffer`

## Requirements
- R1: While reset is held, `cpu_ack_o` and `mem_req_o` are 0. After reset the queue is empty, so a fence is acknowledged in the cycle it is presented.
- R2: When `mode_i` is 2'b01, 2'b10 or 2'b11 and the queue has a free entry, a store (`cpu_req_i`=1, `cpu_fence_i`=0, `cpu_we_i`=1) is acknowledged in the cycle it is presented, whatever the state of memory.
- R3: When `mode_i` is 2'b00, nothing enters the queue. A store is acknowledged only in the cycle its memory write completes (`mem_resp_i`). A load is acknowledged only with its memory response.
- R4: When `mode_i` is 2'b01, a load is sent to memory only while the queue is empty, so every earlier store has been written before the load is answered.
- R5: When `mode_i[1]` is 1, a load that matches no queued address may go to memory while stores are still queued. If such a load and a queue drain are both ready in the same cycle, the load is issued first.
- R6: When `mode_i[1]` is 1, a load whose address matches a queued store is acknowledged in the cycle it is presented. It returns the data of the youngest matching entry and makes no memory access.
- R7: Queued stores are written to memory in acceptance order, each exactly once. An entry leaves the queue only when memory answers its write.
- R8: While the queue holds DEPTH entries, a store is not acknowledged until an entry has drained.
- R9: A fence (`cpu_fence_i`=1 with `cpu_req_i`=1; `cpu_we_i` is then ignored) is acknowledged only when the queue is empty and no write is in flight, in every mode.
- R10: In every mode, each load returns the value of the most recent store to that address in acknowledgement order, or the memory's prior contents if there was none.
- R11: At most one memory request is outstanding: after a request is accepted (`mem_req_o` and `mem_rdy_i`), `mem_req_o` stays low until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Ordering policy: 00 synchronous, 01 queued in-order loads, 1x queued with load overtaking |
| cpu_req_i | input | 1 | Processor request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_fence_i | input | 1 | Request is a fence |
| cpu_addr_i | input | ADDR_W | Access address |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ack_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Load data, valid with `cpu_ack_o` |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdy_i | input | 1 | Memory accepts the request this cycle |
| mem_resp_i | input | 1 | Memory completes the outstanding request |
| mem_rdata_i | input | DATA_W | Memory read data, valid with `mem_resp_i` |

## Verification
The assertions check, on every cycle, the properties that follow from the local state. Nothing enters the queue in the synchronous policy. A load reaches memory in the in-order policy only with an empty queue. The queue is never pushed when full or popped when empty, a full queue never acknowledges a store, a fence is acknowledged only with an empty queue, and the memory port never has two requests in flight. Other properties need a memory model with latency and a reference store history, so only the bench's scenarios can show them. These are load overtaking, forwarding from the youngest of several matching entries, write order at memory, and load values in every policy under random mixes of operations and policy switches.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam logic [1:0] MODE_SYNC    = 2'b00;
    localparam logic [1:0] MODE_INORDER = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SYNC  = 2'd2,
        ST_DRAIN = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] head_addr_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic              empty_o,
    output logic              full_o,
    input  logic [ADDR_W-1:0] look_addr_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] hit_data_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        logic [PTR_W-1:0]   rd;
        logic [PTR_W-1:0]   wr;
        logic [CNT_W-1:0]   cnt;
        slot_t [DEPTH-1:0]  slots;
    } q_regs_t;

    q_regs_t s_q, s_d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push_i) begin
            s_d.slots[s_q.wr].addr = push_addr_i;
            s_d.slots[s_q.wr].data = push_data_i;
            s_d.wr = bump(s_q.wr);
        end
        if (pop_i) begin
            s_d.rd = bump(s_q.rd);
        end
        case ({push_i, pop_i})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign empty_o     = (s_q.cnt == '0);
    assign full_o      = (s_q.cnt == CNT_W'(DEPTH));
    assign head_addr_o = s_q.slots[s_q.rd].addr;
    assign head_data_o = s_q.slots[s_q.rd].data;

    // Per-age match: age 0 is the oldest live entry.
    logic [DEPTH-1:0] age_hit;
    logic [DATA_W-1:0] age_data [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [PTR_W-1:0] idx;
        always_comb begin
            idx = PTR_W'((int'(s_q.rd) + k) % DEPTH);
        end
        assign age_hit[k]  = (CNT_W'(k) < s_q.cnt) && (s_q.slots[idx].addr == look_addr_i);
        assign age_data[k] = s_q.slots[idx].data;
    end

    // Youngest match wins: later ages overwrite earlier ones.
    always_comb begin
        hit_data_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (age_hit[k]) begin
                hit_data_o = age_data[k];
            end
        end
    end
    assign hit_o = |age_hit;

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (s_q.cnt < CNT_W'(DEPTH)));

    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (s_q.cnt != '0));

    p_count_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic              cpu_fence_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_ack_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    input  logic              q_empty_i,
    input  logic              q_full_i,
    input  logic              q_hit_i,
    input  logic [DATA_W-1:0] q_hit_data_i,
    input  logic [ADDR_W-1:0] q_head_addr_i,
    input  logic [DATA_W-1:0] q_head_data_i,
    output logic              push_o,
    output logic              pop_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_rdy_i,
    input  logic              mem_resp_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    import sb_pkg::*;

    typedef struct packed {
        ctl_state_e st;
    } ctl_regs_t;

    ctl_regs_t s_q, s_d;

    logic buffered, bypass, cpu_free, want_ld, want_st;

    assign buffered = (mode_i != MODE_SYNC);
    assign bypass   = mode_i[1];
    // The processor may present a new request unless its own access is in flight.
    assign cpu_free = (s_q.st == ST_IDLE) || (s_q.st == ST_DRAIN);

    always_comb begin
        s_d         = s_q;
        cpu_ack_o   = 1'b0;
        cpu_rdata_o = '0;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = q_head_addr_i;
        mem_wdata_o = q_head_data_i;
        want_ld     = 1'b0;
        want_st     = 1'b0;

        if (cpu_free && cpu_req_i) begin
            if (cpu_fence_i) begin
                if ((s_q.st == ST_IDLE) && q_empty_i) begin
                    cpu_ack_o = 1'b1;
                end
            end else if (cpu_we_i) begin
                if (buffered) begin
                    if (!q_full_i) begin
                        push_o    = 1'b1;
                        cpu_ack_o = 1'b1;
                    end
                end else if ((s_q.st == ST_IDLE) && q_empty_i) begin
                    want_st = 1'b1;
                end
            end else begin
                if (bypass && q_hit_i) begin
                    cpu_ack_o   = 1'b1;
                    cpu_rdata_o = q_hit_data_i;
                end else if ((s_q.st == ST_IDLE) && (bypass || q_empty_i)) begin
                    want_ld = 1'b1;
                end
            end
        end

        case (s_q.st)
            ST_IDLE: begin
                if (want_ld || want_st) begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = want_st;
                    mem_addr_o  = cpu_addr_i;
                    mem_wdata_o = cpu_wdata_i;
                    if (mem_rdy_i) begin
                        s_d.st = want_ld ? ST_LOAD : ST_SYNC;
                    end
                end else if (!q_empty_i) begin
                    mem_req_o = 1'b1;
                    mem_we_o  = 1'b1;
                    if (mem_rdy_i) begin
                        s_d.st = ST_DRAIN;
                    end
                end
            end
            ST_LOAD: begin
                if (mem_resp_i) begin
                    cpu_ack_o   = 1'b1;
                    cpu_rdata_o = mem_rdata_i;
                    s_d.st      = ST_IDLE;
                end
            end
            ST_SYNC: begin
                if (mem_resp_i) begin
                    cpu_ack_o = 1'b1;
                    s_d.st    = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (mem_resp_i) begin
                    pop_o  = 1'b1;
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    p_sync_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (mode_i != MODE_SYNC));

    p_inorder_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && (mode_i == MODE_INORDER)) |-> q_empty_i);

    p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rdy_i) |=> !mem_req_o);

    p_fence_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_o && cpu_req_i && cpu_fence_i) |-> q_empty_i);

    p_full_holds_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full_i && cpu_req_i && cpu_we_i && !cpu_fence_i) |-> !cpu_ack_o);
endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic              cpu_fence_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_ack_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_rdy_i,
    input  logic              mem_resp_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    logic              q_push, q_pop, q_empty, q_full, q_hit;
    logic [ADDR_W-1:0] q_head_addr;
    logic [DATA_W-1:0] q_head_data, q_hit_data;

    sb_queue #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (q_push),
        .push_addr_i (cpu_addr_i),
        .push_data_i (cpu_wdata_i),
        .pop_i       (q_pop),
        .head_addr_o (q_head_addr),
        .head_data_o (q_head_data),
        .empty_o     (q_empty),
        .full_o      (q_full),
        .look_addr_i (cpu_addr_i),
        .hit_o       (q_hit),
        .hit_data_o  (q_hit_data)
    );

    sb_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .cpu_req_i     (cpu_req_i),
        .cpu_we_i      (cpu_we_i),
        .cpu_fence_i   (cpu_fence_i),
        .cpu_addr_i    (cpu_addr_i),
        .cpu_wdata_i   (cpu_wdata_i),
        .cpu_ack_o     (cpu_ack_o),
        .cpu_rdata_o   (cpu_rdata_o),
        .q_empty_i     (q_empty),
        .q_full_i      (q_full),
        .q_hit_i       (q_hit),
        .q_hit_data_i  (q_hit_data),
        .q_head_addr_i (q_head_addr),
        .q_head_data_i (q_head_data),
        .push_o        (q_push),
        .pop_o         (q_pop),
        .mem_req_o     (mem_req_o),
        .mem_we_o      (mem_we_o),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o),
        .mem_rdy_i     (mem_rdy_i),
        .mem_resp_i    (mem_resp_i),
        .mem_rdata_i   (mem_rdata_i)
    );
endmodule

// File: tb/test_store_buffer.sv
module test_store_buffer;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [1:0]    mode;
    logic          cpu_req, cpu_we, cpu_fence;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rdy, mem_resp;
    logic [DW-1:0] mem_rdata;

    store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_store_buffer (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_fence_i(cpu_fence),
        .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
        .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdy_i(mem_rdy), .mem_resp_i(mem_resp),
        .mem_rdata_i(mem_rdata)
    );

    int total = 0;
    int bad = 0;
    int wcount = 0;
    int stores_acked = 0;
    int rdy_mode = 0;   // 0 random, 1 always ready, 2 never ready
    logic [DW-1:0] bmem [256];
    logic [DW-1:0] refm [256];
    logic [AW-1:0] log_a [1024];
    logic [DW-1:0] log_d [1024];
    logic [AW-1:0] exp_a [1024];
    logic [DW-1:0] exp_d [1024];

    function automatic logic [DW-1:0] init_val(input int i);
        return DW'(i * 32'h0101_0007 + 32'h55);
    endfunction

    function automatic logic [DW-1:0] exp_load(input logic [AW-1:0] a);
        return refm[a];
    endfunction

    // Memory model: one request at a time, 1..3 cycles to respond.
    logic          pend;
    int            lat;
    logic [AW-1:0] p_addr;
    always @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            mem_resp <= 1'b0;
            mem_rdy  <= 1'b0;
            mem_rdata <= '0;
            lat      <= 0;
            for (int i = 0; i < 256; i++) bmem[i] <= init_val(i);
        end else begin
            mem_resp <= 1'b0;
            if (mem_req && mem_rdy) begin
                pend   <= 1'b1;
                lat    <= int'($urandom % 3);
                p_addr <= mem_addr;
                if (mem_we) begin
                    bmem[mem_addr] <= mem_wdata;
                    log_a[wcount]  <= mem_addr;
                    log_d[wcount]  <= mem_wdata;
                    wcount         <= wcount + 1;
                end
            end else if (pend) begin
                if (lat == 0) begin
                    mem_resp  <= 1'b1;
                    mem_rdata <= bmem[p_addr];
                    pend      <= 1'b0;
                end else begin
                    lat <= lat - 1;
                end
            end
            mem_rdy <= (rdy_mode == 1) || ((rdy_mode == 0) && (($urandom % 4) != 0));
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input bit fe, input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int maxc,
                         output bit got, output int cyc, output logic [DW-1:0] rd);
        cpu_req = 1'b1; cpu_fence = fe; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        got = 1'b0; cyc = 0; rd = '0;
        while (!got && cyc < maxc) begin
            #3;
            if (cpu_ack) begin
                got = 1'b1;
                rd = cpu_rdata;
            end
            @(negedge clk);
            if (!got) cyc++;
        end
        cpu_req = 1'b0; cpu_fence = 1'b0; cpu_we = 1'b0;
        if (got && we && !fe) begin
            refm[a] = d;
            exp_a[stores_acked] = a;
            exp_d[stores_acked] = d;
            stores_acked++;
        end
    endtask

    task automatic set_rdy(input int m);
        rdy_mode = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic release_after(input int n);
        repeat (n) @(negedge clk);
        rdy_mode = 1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    bit got;
    int cyc;
    logic [DW-1:0] rd;

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) refm[i] = init_val(i);
        rst_n = 1'b0; mode = 2'b10; cpu_req = 0; cpu_we = 0; cpu_fence = 0;
        cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        check(cpu_ack == 1'b0, "R1", "ack in reset", DW'(cpu_ack), 0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", DW'(mem_req), 0);
        rst_n = 1'b1;
        set_rdy(2);

        do_op(1, 0, 8'h00, 0, 20, got, cyc, rd);
        check(got && cyc == 0, "R1", "fence on empty queue wait", DW'(cyc), 0);

        // R2: store taken at once while memory is stalled
        do_op(0, 1, 8'h30, 32'hAAAA_0001, 20, got, cyc, rd);
        check(got && cyc == 0, "R2", "buffered store wait", DW'(cyc), 0);
        // R6: two stores to one address, load takes the younger
        do_op(0, 1, 8'h10, 32'h11, 20, got, cyc, rd);
        do_op(0, 1, 8'h10, 32'h22, 20, got, cyc, rd);
        do_op(0, 0, 8'h10, 0, 20, got, cyc, rd);
        check(got && cyc == 0, "R6", "forwarded load wait", DW'(cyc), 0);
        check(rd == 32'h22, "R6", "forwarded data", rd, 32'h22);
        check(wcount == 0, "R6", "writes during forward", DW'(wcount), 0);

        // R5: load miss overtakes three queued stores
        fork
            do_op(0, 0, 8'h20, 0, 100, got, cyc, rd);
            release_after(4);
        join
        check(got && rd == exp_load(8'h20), "R5", "overtaking load data", rd, exp_load(8'h20));
        check(wcount == 0, "R5", "writes before overtaking load", DW'(wcount), 0);
        do_op(1, 0, 8'h00, 0, 200, got, cyc, rd);
        check(got && wcount == stores_acked, "R9", "writes at fence", DW'(wcount), DW'(stores_acked));

        // R8: full queue holds a store
        mode = 2'b01;
        set_rdy(2);
        for (int i = 0; i < DEPTH; i++) begin
            do_op(0, 1, AW'(8'h40 + i), DW'(32'hB000 + i), 20, got, cyc, rd);
            check(got && cyc == 0, "R2", "fill store wait", DW'(cyc), 0);
        end
        fork
            do_op(0, 1, 8'h48, 32'hB0FF, 200, got, cyc, rd);
            release_after(8);
        join
        check(got && cyc >= 8, "R8", "store held while full", DW'(cyc), 8);

        // R9: fence waits for queued stores
        mode = 2'b10;
        set_rdy(2);
        do_op(0, 1, 8'h50, 32'hC1, 20, got, cyc, rd);
        do_op(0, 1, 8'h51, 32'hC2, 20, got, cyc, rd);
        fork
            do_op(1, 0, 8'h00, 0, 200, got, cyc, rd);
            release_after(6);
        join
        check(got && cyc >= 6, "R9", "fence held by pending stores", DW'(cyc), 6);
        check(wcount == stores_acked, "R9", "writes at fence", DW'(wcount), DW'(stores_acked));

        // R4: in-order load waits for queued stores
        mode = 2'b01;
        set_rdy(2);
        do_op(0, 1, 8'h60, 32'hD1, 20, got, cyc, rd);
        do_op(0, 1, 8'h61, 32'hD2, 20, got, cyc, rd);
        fork
            do_op(0, 0, 8'h60, 0, 200, got, cyc, rd);
            release_after(3);
        join
        check(wcount == stores_acked, "R4", "writes done before load", DW'(wcount), DW'(stores_acked));
        check(got && rd == 32'hD1, "R4", "in-order load data", rd, 32'hD1);

        // R3: synchronous policy
        mode = 2'b00;
        set_rdy(1);
        do_op(0, 1, 8'h70, 32'hE1, 200, got, cyc, rd);
        check(got && cyc >= 1 && wcount == stores_acked, "R3", "sync store written at ack",
              DW'(wcount), DW'(stores_acked));
        do_op(0, 0, 8'h70, 0, 200, got, cyc, rd);
        check(got && cyc >= 1 && rd == 32'hE1, "R3", "sync load data", rd, 32'hE1);

        // Random mix across all policies (R10)
        rdy_mode = 0;
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] e;
            int r;
            if (i % 25 == 0) mode = 2'($urandom % 4);
            r = int'($urandom % 100);
            a = AW'($urandom % 8);
            if (r < 45) begin
                do_op(0, 1, a, $urandom, 300, got, cyc, rd);
                check(got, "R10", "random store completes", DW'(got), 1);
            end else if (r < 85) begin
                e = exp_load(a);
                do_op(0, 0, a, 0, 300, got, cyc, rd);
                check(got && rd == e, "R10", "random load data", rd, e);
            end else begin
                do_op(1, 0, a, 0, 300, got, cyc, rd);
                check(got && wcount == stores_acked, "R9", "random fence drained",
                      DW'(wcount), DW'(stores_acked));
            end
        end

        // R7: write order at memory
        do_op(1, 0, 8'h00, 0, 300, got, cyc, rd);
        check(wcount == stores_acked, "R7", "write count", DW'(wcount), DW'(stores_acked));
        begin
            int mism = 0;
            for (int i = 0; i < stores_acked; i++) begin
                if (log_a[i] != exp_a[i] || log_d[i] != exp_d[i]) mism++;
            end
            check(mism == 0, "R7", "writes out of order", DW'(mism), 0);
        end
        finish_run();
    end
endmodule